// File: doc/BRIEF.md
# Addressed SPI Register Port for a GPIO Expander

This block is the serial front end of an 8-bit port-expander register file. It is an SPI mode 0 slave that shifts MSB first. Up to eight copies can sit on one chip select, and each copy is told apart by three strapped address pins. Each frame opens with a command byte. Its top nibble is the fixed device code 0100b, bits [3:1] carry the target's strap address, and bit 0 selects the direction: 1 reads and 0 writes. The second byte names a register. Every byte after that is write data, or a slot in which read data is returned on MISO.

The register file itself sits outside the block and provides two configuration bits. One bit turns the strap-address compare on. When it is off, the address field is ignored and every device answers. The other bit freezes the register pointer during a burst. The block drives single-cycle write and read strobes with a register index. Read data comes back combinationally on `reg_rdata` while the index is presented. MISO is given as a data bit and an output enable, and the pad tri-states it. The SPI pins are assumed to be already synchronous to `clk`, which must run at least four times faster than SCLK.

Top module: `spi_xp_slave`

## Requirements
- R1: Out of reset, and while chip select is high, `miso_oe`, `reg_wr_en` and `reg_rd_en` are all low.
- R2: A command byte whose upper nibble is not 0100b causes no strobe for the rest of the frame and keeps MISO released.
- R3: With `cfg_addr_en` high, a command whose bits [3:1] differ from `hw_addr` causes no strobe, and `miso_oe` stays low for the whole frame.
- R4: With `cfg_addr_en` low, bits [3:1] of the command are ignored and the device answers any of the eight values.
- R5: In a write frame (command bit 0 = 0), the byte after the command sets the register pointer. Each completed data byte raises `reg_wr_en` for one `clk` cycle with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte, in the cycle after the eighth rising SCLK edge is seen.
- R6: With `cfg_seq_off` low, the pointer advances by one after each data byte. Past the last valid register (0x0A) it wraps to 0x00.
- R7: With `cfg_seq_off` high, the pointer stays at the address given in the frame for every data byte.
- R8: In a read frame (command bit 0 = 1), each data byte is loaded at the falling SCLK edge that ends the previous byte, with one `reg_rd_en` pulse. Its MSB is valid before the next rising edge. The falling edge after the final byte fetches one more byte, which is discarded.
- R9: A pointer above 0x0A gives no write strobe and no read strobe. Such a read returns 0x00.
- R10: Raising chip select abandons the frame, including a partial byte, and the next frame is parsed from its command byte.
- R11: `miso_oe` is high only in the data phase of a matched read frame with chip select low. It is low during write frames.
- R12: The write and read strobes are never high together, and neither lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Shared chip select, active low |
| sclk | input | 1 | SPI clock, idle low |
| mosi | input | 1 | Serial data in |
| hw_addr | input | 3 | Strapped device address |
| cfg_addr_en | input | 1 | Enables the strap-address compare |
| cfg_seq_off | input | 1 | Freezes the register pointer in a burst |
| miso_o | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for MISO |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_addr | output | 4 | Register index for either strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data for `reg_addr`, combinational |

## Verification
An SCLK edge is acted on at the first `clk` edge after it changes. Write strobes and read strobes follow one cycle later. A read byte reaches the MISO shifter two `clk` edges after the falling SCLK edge. The bench drives every pin at `clk` falling edges and keeps each SCLK phase four cycles long. It samples MISO and its enable at the last falling `clk` edge before it raises SCLK, which is after the data is due. Strobes are compared with a queue predicted from the requirements at every falling `clk` edge, and each frame must leave that queue empty.

// File: rtl/spi_xp_pkg.sv
// Shared constants and the frame phase type for the addressed SPI register port.
package spi_xp_pkg;
    localparam int          BYTE_W   = 8;
    localparam int          HWA_W    = 3;
    localparam logic [3:0]  DEV_CODE = 4'b0100;

    typedef enum logic [1:0] {
        PH_OPCODE,
        PH_REGADDR,
        PH_DATA,
        PH_IGNORE
    } phase_t;
endpackage

// File: rtl/spi_xp_edge.sv
// Detects SCLK edges inside a frame.
// Assumes sclk and cs_n are already synchronous to clk.
module spi_xp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    // Remember the SCLK level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q & ~cs_n;
    assign fall = ~sclk & sclk_q & ~cs_n;
endmodule

// File: rtl/spi_xp_rx.sv
// Collects MOSI bits MSB first and flags each completed byte.
// The byte is flagged combinationally, in the cycle of its last rising edge.
module spi_xp_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         rise,
    input  logic         mosi,
    output logic         byte_ok,
    output logic [W-1:0] byte_val
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

    logic [W-2:0]  sh;
    logic [CW-1:0] cnt;

    // Shift in a bit on every rising edge; chip select high drops a partial byte.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (rise) begin
            sh  <= {sh[W-3:0], mosi};
            cnt <= (cnt == LAST_BIT) ? '0 : cnt + 1'b1;
        end
    end

    assign byte_ok  = rise && (cnt == LAST_BIT);
    assign byte_val = {sh, mosi};
endmodule

// File: rtl/spi_xp_tx.sv
// MISO shifter: loads a whole byte, then shifts one bit out on each falling edge.
// The enable is held from the first load until chip select rises.
module spi_xp_tx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         load,
    input  logic [W-1:0] fill,
    input  logic         fall,
    output logic         miso_o,
    output logic         miso_oe
);
    logic [W-1:0] sh;
    logic         live;

    // Load has priority; otherwise advance on a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            sh   <= '0;
            live <= 1'b0;
        end else if (load) begin
            sh   <= fill;
            live <= 1'b1;
        end else if (fall) begin
            sh   <= {sh[W-2:0], 1'b0};
        end
    end

    assign miso_o  = sh[W-1];
    assign miso_oe = live & ~cs_n;
endmodule

// File: rtl/spi_xp_seq.sv
// Register pointer. It is set from the address byte and stepped after each data byte.
// It wraps from the last valid register to zero and is frozen while hold is high.
module spi_xp_seq #(
    parameter int W        = 8,
    parameter int NUM_REGS = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set,
    input  logic [W-1:0] set_val,
    input  logic         step,
    input  logic         hold,
    output logic [W-1:0] ptr,
    output logic         in_range
);
    localparam logic [W-1:0] LAST = W'(NUM_REGS - 1);

    // Set, step or keep the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)              ptr <= '0;
        else if (set)            ptr <= set_val;
        else if (step && !hold)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    assign in_range = (ptr <= LAST);
endmodule

// File: rtl/spi_xp_slave.sv
// Addressed SPI mode 0 slave for an expander register file.
// Parses command, register address and data bytes, and drives register strobes.
// Assumes the SPI pins are synchronous to clk, clk >= 4x SCLK, and reg_rdata
// follows reg_addr combinationally.
module spi_xp_slave
    import spi_xp_pkg::*;
#(
    parameter int NUM_REGS = 11,
    localparam int REG_AW  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic [HWA_W-1:0]  hw_addr,
    input  logic              cfg_addr_en,
    input  logic              cfg_seq_off,
    output logic              miso_o,
    output logic              miso_oe,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic [REG_AW-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata
);
    logic              rise, fall, byte_ok, op_hit;
    logic [BYTE_W-1:0] byte_val, ptr;
    logic              ptr_ok, ptr_set, ptr_step;
    phase_t            phase;
    logic              rd_mode, fetch, load_q, rng_q;
    logic [BYTE_W-1:0] fill;

    spi_xp_edge u_edge (
        .clk (clk), .rst_n (rst_n), .sclk (sclk), .cs_n (cs_n),
        .rise (rise), .fall (fall)
    );

    spi_xp_rx #(.W(BYTE_W)) u_rx (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .rise (rise), .mosi (mosi),
        .byte_ok (byte_ok), .byte_val (byte_val)
    );

    // The command matches on the device code, and on the strap address when enabled.
    assign op_hit = (byte_val[BYTE_W-1 -: 4] == DEV_CODE) &&
                    (!cfg_addr_en || byte_val[HWA_W:1] == hw_addr);

    assign ptr_set  = byte_ok && (phase == PH_REGADDR);
    assign ptr_step = (fall && fetch) ||
                      (byte_ok && (phase == PH_DATA) && !rd_mode);

    spi_xp_seq #(.W(BYTE_W), .NUM_REGS(NUM_REGS)) u_seq (
        .clk (clk), .rst_n (rst_n), .set (ptr_set), .set_val (byte_val),
        .step (ptr_step), .hold (cfg_seq_off), .ptr (ptr), .in_range (ptr_ok)
    );

    // Frame parser, strobe generation and read prefetch.
    always_ff @(posedge clk) begin
        reg_wr_en <= 1'b0;
        reg_rd_en <= 1'b0;
        load_q    <= 1'b0;
        if (!rst_n) begin
            phase     <= PH_OPCODE;
            rd_mode   <= 1'b0;
            fetch     <= 1'b0;
            rng_q     <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
        end else if (cs_n) begin
            phase   <= PH_OPCODE;
            rd_mode <= 1'b0;
            fetch   <= 1'b0;
        end else begin
            if (byte_ok) begin
                unique case (phase)
                    PH_OPCODE: begin
                        rd_mode <= byte_val[0];
                        phase   <= op_hit ? PH_REGADDR : PH_IGNORE;
                    end
                    PH_REGADDR: begin
                        phase <= PH_DATA;
                        fetch <= rd_mode;
                    end
                    PH_DATA: begin
                        if (rd_mode) begin
                            fetch <= 1'b1;
                        end else if (ptr_ok) begin
                            reg_wr_en <= 1'b1;
                            reg_addr  <= ptr[REG_AW-1:0];
                            reg_wdata <= byte_val;
                        end
                    end
                    default: ;
                endcase
            end
            if (fall && fetch) begin
                fetch     <= 1'b0;
                load_q    <= 1'b1;
                rng_q     <= ptr_ok;
                reg_rd_en <= ptr_ok;
                if (ptr_ok) reg_addr <= ptr[REG_AW-1:0];
            end
        end
    end

    assign fill = rng_q ? reg_rdata : '0;

    spi_xp_tx #(.W(BYTE_W)) u_tx (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .load (load_q), .fill (fill),
        .fall (fall), .miso_o (miso_o), .miso_oe (miso_oe)
    );
endmodule

// File: rtl/spi_xp_chk.sv
// Protocol checks for spi_xp_slave, attached by bind.
module spi_xp_chk #(
    parameter int NUM_REGS = 11,
    localparam int REG_AW  = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              miso_oe,
    input logic              reg_wr_en,
    input logic              reg_rd_en,
    input logic [REG_AW-1:0] reg_addr
);
    // R12
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));
    // R12
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);
    // R12
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en);
    // R9
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || reg_rd_en) |-> (int'(reg_addr) < NUM_REGS));
    // R11
    oe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !miso_oe);
    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> !(reg_wr_en || reg_rd_en));
endmodule

bind spi_xp_slave spi_xp_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .miso_oe (miso_oe),
    .reg_wr_en (reg_wr_en), .reg_rd_en (reg_rd_en), .reg_addr (reg_addr)
);

// File: tb/sim_spi_xp_slave.sv
module sim_spi_xp_slave;
    localparam int HALF = 4;
    localparam int LAST = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic [2:0] hw_addr = 3'd5;
    logic       cfg_addr_en = 1'b1, cfg_seq_off = 1'b0;
    logic       miso_o, miso_oe, reg_wr_en, reg_rd_en;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] rf [16];
    logic [7:0] em [16];
    int checks = 0, failures = 0;
    int exp_kind[$], exp_addr[$], exp_data[$];
    bit quiet = 1'b1, done = 1'b0, oe_all = 1'b1, wr_prev = 1'b0, rd_prev = 1'b0;

    always #5 clk = ~clk;

    spi_xp_slave u0 (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk), .mosi (mosi),
        .hw_addr (hw_addr), .cfg_addr_en (cfg_addr_en), .cfg_seq_off (cfg_seq_off),
        .miso_o (miso_o), .miso_oe (miso_oe), .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // Register file on the device side of the port.
    assign reg_rdata = rf[reg_addr];
    always @(posedge clk) if (reg_wr_en) rf[reg_addr] <= reg_wdata;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Each strobe must match the head of the predicted queue.
    always @(negedge clk) if (rst_n) begin
        if (reg_wr_en) begin
            if (exp_kind.size() == 0) chk(0, "R5 unexpected write", reg_addr, -1);
            else begin
                chk(exp_kind[0] == 0, "R5 strobe kind", 0, exp_kind[0]);
                chk(reg_addr == exp_addr[0], "R6 write address", reg_addr, exp_addr[0]);
                chk(reg_wdata == exp_data[0], "R5 write data", reg_wdata, exp_data[0]);
                void'(exp_kind.pop_front()); void'(exp_addr.pop_front()); void'(exp_data.pop_front());
            end
        end
        if (reg_rd_en) begin
            if (exp_kind.size() == 0) chk(0, "R8 unexpected read strobe", reg_addr, -1);
            else begin
                chk(exp_kind[0] == 1, "R8 strobe kind", 1, exp_kind[0]);
                chk(reg_addr == exp_addr[0], "R8 read address", reg_addr, exp_addr[0]);
                void'(exp_kind.pop_front()); void'(exp_addr.pop_front()); void'(exp_data.pop_front());
            end
        end
        if ((reg_wr_en && wr_prev) || (reg_rd_en && rd_prev) || (reg_wr_en && reg_rd_en))
            chk(0, "R12 strobe width", {reg_wr_en, reg_rd_en}, 0);
        if (quiet && miso_oe) chk(0, "R11 MISO enabled outside read data", 1, 0);
        wr_prev = reg_wr_en;
        rd_prev = reg_rd_en;
    end

    function automatic int nxt(input int a);
        if (cfg_seq_off) return a;
        return (a == LAST) ? 0 : ((a + 1) & 255);
    endfunction

    function automatic bit hit(input logic [7:0] op);
        return op[7:4] == 4'b0100 && (!cfg_addr_en || op[3:1] == hw_addr);
    endfunction

    task automatic push(input int k, input int a, input int d);
        exp_kind.push_back(k); exp_addr.push_back(a); exp_data.push_back(d);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso_o;
            oe_all &= miso_oe;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic open_frame();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic close_frame(input string tag);
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        quiet = 1'b1;
        repeat (2 * HALF) @(negedge clk);
        chk(exp_kind.size() == 0, tag, exp_kind.size(), 0);
        exp_kind.delete(); exp_addr.delete(); exp_data.delete();
    endtask

    task automatic write_frame(input logic [7:0] op, input int a0, input logic [7:0] d[$], input string tag);
        logic [7:0] rx;
        int a = a0;
        if (hit(op) && !op[0])
            foreach (d[i]) begin
                if (a <= LAST) begin push(0, a, d[i]); em[a] = d[i]; end
                a = nxt(a);
            end
        quiet = 1'b1;
        open_frame();
        spi_bits(op, 8, rx);
        spi_bits(8'(a0), 8, rx);
        foreach (d[i]) spi_bits(d[i], 8, rx);
        close_frame(tag);
    endtask

    task automatic read_frame(input logic [7:0] op, input int a0, input int n, input string tag);
        logic [7:0] rx;
        int a = a0;
        bit m = hit(op) && op[0];
        int vals[$];
        if (m)
            for (int k = 0; k <= n; k++) begin
                if (a <= LAST) push(1, a, 0);
                vals.push_back(a <= LAST ? int'(em[a]) : 0);
                a = nxt(a);
            end
        quiet = 1'b1;
        open_frame();
        spi_bits(op, 8, rx);
        spi_bits(8'(a0), 8, rx);
        quiet = !m;
        for (int k = 0; k < n; k++) begin
            oe_all = 1'b1;
            spi_bits(8'h00, 8, rx);
            if (m) begin
                chk(rx == vals[k][7:0], {tag, " read byte"}, rx, vals[k]);
                chk(oe_all, "R11 MISO enabled in read data", oe_all, 1);
            end
        end
        close_frame(tag);
    endtask

    initial begin
        logic [7:0] rx;
        for (int i = 0; i < 16; i++) begin rf[i] = 8'h30 + 8'(i); em[i] = 8'h30 + 8'(i); end
        repeat (3) @(negedge clk);
        chk(!miso_oe && !reg_wr_en && !reg_rd_en, "R1 reset outputs", {miso_oe, reg_wr_en, reg_rd_en}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!miso_oe && !reg_wr_en && !reg_rd_en, "R1 idle outputs", {miso_oe, reg_wr_en, reg_rd_en}, 0);

        // R5 R6: burst write with stepping, then read back (R8)
        write_frame(8'h4A, 2, '{8'h11, 8'h22, 8'h33}, "R5 burst write");
        read_frame(8'h4B, 2, 3, "R8 burst read");
        // R6: wrap from the last register to zero
        write_frame(8'h4A, 9, '{8'hA1, 8'hA2, 8'hA3}, "R6 wrap write");
        read_frame(8'h4B, LAST, 2, "R6 wrap read");
        // R7: frozen pointer
        cfg_seq_off = 1'b1;
        write_frame(8'h4A, 6, '{8'h05, 8'h06, 8'h07}, "R7 fixed write");
        read_frame(8'h4B, 6, 2, "R7 fixed read");
        cfg_seq_off = 1'b0;
        // R3: strap mismatch is ignored
        write_frame(8'h46, 1, '{8'hFF}, "R3 mismatch write");
        read_frame(8'h47, 1, 2, "R3 mismatch read");
        chk(rf[1] == em[1], "R3 register untouched", rf[1], em[1]);
        // R4: compare disabled, any strap value answers
        cfg_addr_en = 1'b0;
        write_frame(8'h46, 1, '{8'h5A}, "R4 any address write");
        read_frame(8'h41, 1, 1, "R4 any address read");
        // R2: wrong device code
        write_frame(8'h50, 4, '{8'h99}, "R2 bad code write");
        read_frame(8'hC1, 4, 1, "R2 bad code read");
        chk(rf[4] == em[4], "R2 register untouched", rf[4], em[4]);
        cfg_addr_en = 1'b1;
        // R9: out-of-range pointer
        write_frame(8'h4A, 12, '{8'h77, 8'h78}, "R9 range write");
        read_frame(8'h4B, 12, 2, "R9 range read");
        // R10: abort mid-data and mid-command, then a clean frame
        quiet = 1'b1;
        open_frame();
        spi_bits(8'h4A, 8, rx);
        spi_bits(8'h05, 8, rx);
        spi_bits(8'hF0, 4, rx);
        close_frame("R10 abort in data");
        chk(rf[5] == em[5], "R10 partial byte dropped", rf[5], em[5]);
        open_frame();
        spi_bits(8'h4B, 5, rx);
        close_frame("R10 abort in command");
        write_frame(8'h4A, 5, '{8'h3C}, "R10 frame after abort");
        read_frame(8'h4B, 5, 1, "R10 read after abort");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule